// File: doc/BRIEF.md
# Alert Class Escalation Sequencer

This block runs the escalation state machine for one alert class. It watches the class interrupt, an accumulation trigger from a neighbouring counter, and a software clear strobe. While the interrupt stays unserviced, it first runs a programmable interrupt timeout. If that expires, or if the accumulation trigger fires, it steps through four escalation phases, each timed in cycles. After the last phase it parks in a terminal state.

Four escalation outputs are each tied to one phase by a 2-bit index and gated by their own enable bit. The block keeps a clear-permission flag. Software can drop this flag. Hardware drops it at trigger time when the lock option is set, so a locked sequence cannot be aborted. The state code and the running cycle count are exposed for readout.

Top module: `esc_class_fsm`

## Requirements
- R1: After reset the state code is 000, the count is 0, all escalation outputs are low and the clear-permission flag is 1.
- R2: State codes are fixed: idle 000, timeout 001, terminal 011, phase k 1kk (phase0 100, phase1 101, phase2 110, phase3 111). Code 010 never appears.
- R3: From idle, with the interrupt pending, escalation enabled and a nonzero timeout value, the next state is timeout. A timeout value of 0 keeps the block in idle.
- R4: Timeout lasts exactly the programmed number of cycles. If the interrupt is still pending at the end, the next state is phase0.
- R5: Deasserting the interrupt while in timeout returns the block to idle on the next edge, unless an accumulation trigger is taken in that cycle.
- R6: An accumulation trigger with escalation enabled moves the block to phase0 from idle or from timeout. It takes priority over the other rules in those states.
- R7: Phase k lasts max(1, length k) cycles, where length k is bits [32k+31:32k] of the phase-length bus. The order is phase0, phase1, phase2, phase3, terminal.
- R8: A clear strobe while the permission flag is 1 returns any phase or the terminal state to idle on the next edge. While the flag is 0, the clear strobe has no effect.
- R9: The permission flag resets to 1. A flag-clear pulse sets it to 0, and it stays 0 until reset.
- R10: When escalation is triggered (entry to phase0 from idle or timeout) with the lock input high, the permission flag is 0 from the first phase0 cycle on.
- R11: Output i is high exactly when its enable bit i is set and the block is in the phase given by map bits [2i+1:2i].
- R12: The terminal state holds with all escalation outputs low and count 0 until a permitted clear.
- R13: The count is 0 in the first cycle of every state. It then rises by one per cycle in timeout and in the phases, and stays 0 in idle and terminal.
- R14: With escalation disabled, neither the interrupt nor the accumulation trigger leaves idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_pending_i | input | 1 | Class interrupt state |
| accum_trig_i | input | 1 | Accumulation threshold trigger |
| clr_i | input | 1 | Escalation clear strobe |
| clr_en_wipe_i | input | 1 | Pulse that drops the clear-permission flag |
| esc_en_i | input | 1 | Escalation mechanisms enable |
| lock_i | input | 1 | Drop clear permission at trigger |
| timeout_cyc_i | input | CNT_W | Interrupt timeout in cycles, 0 disables |
| phase_cyc_i | input | 4*CNT_W | Phase lengths, phase k at bits [CNT_W*k +: CNT_W] |
| sig_en_i | input | N_SIG | Per-output enable |
| sig_map_i | input | 2*N_SIG | Per-output phase index, output i at bits [2i+1:2i] |
| esc_o | output | N_SIG | Escalation outputs |
| state_o | output | 3 | Current state code |
| cnt_o | output | CNT_W | Cycles spent in the current state |
| clr_en_o | output | 1 | Clear-permission flag |

## Verification
The state code, the cycle count and the permission flag are all ports. So a wrong state, a missed transition or a stray count increment shows up as a mismatch at the next clock edge, with no waiting for later effects. Output mapping errors show on the escalation outputs in the same cycle as the phase they belong to. A lock or permission fault shows either as an early drop of the flag or as a clear that is wrongly taken or wrongly refused on the following edge.

// File: rtl/esc_class_fsm.sv
module esc_class_fsm #(
  parameter int CNT_W = 32,
  parameter int N_SIG = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 irq_pending_i,
  input  logic                 accum_trig_i,
  input  logic                 clr_i,
  input  logic                 clr_en_wipe_i,
  input  logic                 esc_en_i,
  input  logic                 lock_i,
  input  logic [CNT_W-1:0]     timeout_cyc_i,
  input  logic [4*CNT_W-1:0]   phase_cyc_i,
  input  logic [N_SIG-1:0]     sig_en_i,
  input  logic [2*N_SIG-1:0]   sig_map_i,
  output logic [N_SIG-1:0]     esc_o,
  output logic [2:0]           state_o,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 clr_en_o
);

  localparam logic [2:0] ST_IDLE = 3'b000;
  localparam logic [2:0] ST_TMO  = 3'b001;
  localparam logic [2:0] ST_TERM = 3'b011;
  localparam logic [2:0] ST_P0   = 3'b100;
  localparam logic [2:0] ST_P3   = 3'b111;

  logic [2:0]       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             clr_en_q;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W-1:0] cur_len;
  logic             trig, abort, in_phase, counting, fire;

  assign trig     = accum_trig_i && esc_en_i;
  assign abort    = clr_i && clr_en_q;
  assign in_phase = state_q[2];
  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign cur_len  = phase_cyc_i[state_q[1:0]*CNT_W +: CNT_W];
  assign counting = in_phase || (state_q == ST_TMO);
  assign fire     = (state_d == ST_P0) && (state_q == ST_IDLE || state_q == ST_TMO);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (trig) state_d = ST_P0;
        else if (irq_pending_i && esc_en_i && timeout_cyc_i != '0) state_d = ST_TMO;
      end
      ST_TMO: begin
        if (trig) state_d = ST_P0;
        else if (!irq_pending_i) state_d = ST_IDLE;
        else if (cnt_inc >= {1'b0, timeout_cyc_i}) state_d = ST_P0;
      end
      ST_TERM: if (abort) state_d = ST_IDLE;
      3'b100, 3'b101, 3'b110, 3'b111: begin
        if (abort) state_d = ST_IDLE;
        else if (cnt_inc >= {1'b0, cur_len}) state_d = (state_q == ST_P3) ? ST_TERM : state_q + 3'd1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cnt_d = (state_d != state_q || !counting) ? '0 : cnt_inc[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      clr_en_q <= 1'b1;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      clr_en_q <= clr_en_q && !clr_en_wipe_i && !(fire && lock_i);
    end
  end

  for (genvar g = 0; g < N_SIG; g++) begin : g_sig
    assign esc_o[g] = sig_en_i[g] && in_phase && (state_q[1:0] == sig_map_i[2*g +: 2]);
  end

  assign state_o  = state_q;
  assign cnt_o    = cnt_q;
  assign clr_en_o = clr_en_q;

  a_r2_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 3'b010);
  a_r9_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_en_o |=> !clr_en_o);
  a_r8_locked_no_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o[2] && !clr_en_o) |=> state_o != ST_IDLE);
  a_r11_quiet_outside_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !state_o[2] |-> esc_o == '0);
  a_r12_terminal_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_TERM && !clr_i) |=> state_o == ST_TERM);
  a_r13_zero_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != $past(state_o)) |-> cnt_o == '0);
  a_r5_irq_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_TMO && !irq_pending_i && !(accum_trig_i && esc_en_i)) |=> state_o == ST_IDLE);
  a_r10_lock_drops_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_IDLE && accum_trig_i && esc_en_i && lock_i) |=> !clr_en_o);

endmodule

// File: tb/esc_class_fsm_tb.sv
module esc_class_fsm_tb;
  localparam int CW = 32;
  localparam int NS = 4;

  logic clk = 0, rst_n = 0;
  logic irq = 0, acc = 0, clr = 0, wipe = 0, en = 0, lock = 0;
  logic [CW-1:0] tmo = '0;
  logic [4*CW-1:0] phc = '0;
  logic [NS-1:0] sen = '1;
  logic [2*NS-1:0] smap = 8'b11_10_01_00;
  logic [NS-1:0] esc;
  logic [2:0] st;
  logic [CW-1:0] cnt;
  logic ce;

  int errors = 0, checks = 0;
  string cur_req = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  esc_class_fsm #(.CNT_W(CW), .N_SIG(NS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_pending_i(irq), .accum_trig_i(acc),
    .clr_i(clr), .clr_en_wipe_i(wipe), .esc_en_i(en), .lock_i(lock),
    .timeout_cyc_i(tmo), .phase_cyc_i(phc), .sig_en_i(sen), .sig_map_i(smap),
    .esc_o(esc), .state_o(st), .cnt_o(cnt), .clr_en_o(ce));

  int m_st = 0;
  longint m_cnt = 0;
  bit m_ce = 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NS-1:0] exp_esc(input int s);
    logic [NS-1:0] r = '0;
    for (int i = 0; i < NS; i++)
      if (sen[i] && s >= 4 && (s - 4) == int'(smap[2*i +: 2])) r[i] = 1'b1;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_ce = 1;
    end else begin
      int nx;
      longint len;
      bit trig, ab;
      nx = m_st;
      trig = acc && en;
      ab = clr && m_ce;
      if (m_st >= 4) begin
        len = longint'(phc[(m_st-4)*CW +: CW]);
        if (len == 0) len = 1;
      end else len = 0;
      if (m_st == 0) begin
        if (trig) nx = 4;
        else if (irq && en && tmo != 0) nx = 1;
      end else if (m_st == 1) begin
        if (trig) nx = 4;
        else if (!irq) nx = 0;
        else if (m_cnt + 1 >= longint'(tmo)) nx = 4;
      end else if (m_st == 3) begin
        if (ab) nx = 0;
      end else begin
        if (ab) nx = 0;
        else if (m_cnt + 1 >= len) nx = (m_st == 7) ? 3 : m_st + 1;
      end
      if (wipe) m_ce = 0;
      if (nx == 4 && (m_st == 0 || m_st == 1) && lock) m_ce = 0;
      if (nx != m_st || m_st == 0 || m_st == 3) m_cnt = 0; else m_cnt = m_cnt + 1;
      m_st = nx;
    end
    #2;
    if (rst_n) begin
      chk(st == 3'(m_st), {cur_req, " state"}, st, m_st);
      chk(cnt == CW'(m_cnt), {cur_req, " count (R13)"}, cnt, m_cnt);
      chk(ce == m_ce, {cur_req, " clear flag"}, ce, m_ce);
      chk(esc == exp_esc(m_st), {cur_req, " outputs (R11)"}, esc, exp_esc(m_st));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_acc();
    acc = 1; step(1); acc = 0;
  endtask

  task automatic pulse_clr();
    clr = 1; step(1); clr = 0;
  endtask

  task automatic set_phases(input int a, input int b, input int c, input int d);
    phc = {CW'(d), CW'(c), CW'(b), CW'(a)};
  endtask

  initial begin
    set_phases(3, 2, 0, 4);
    step(2);
    rst_n = 1;
    step(1);
    cur_req = "R1";
    chk(st == 3'b000 && cnt == 0 && esc == 0 && ce == 1, "R1 reset", st, 0);

    cur_req = "R14";
    irq = 1; tmo = 5; step(2); pulse_acc(); step(1);
    chk(st == 3'b000, "R14 disabled stays idle", st, 0);
    irq = 0;

    cur_req = "R3";
    en = 1; tmo = 0; irq = 1; step(3);
    chk(st == 3'b000, "R3 zero timeout idle", st, 0);
    irq = 0; tmo = 5; step(1);

    cur_req = "R5";
    irq = 1; step(1);
    chk(st == 3'b001, "R3 enter timeout", st, 1);
    step(2); irq = 0; step(1);
    chk(st == 3'b000, "R5 irq abort", st, 0);

    cur_req = "R4";
    irq = 1; step(1);
    chk(st == 3'b001, "R4 timeout", st, 1);
    step(5);
    chk(st == 3'b100 && esc == 4'b0001, "R4 phase0 after timeout", st, 4);
    cur_req = "R7";
    step(3); chk(st == 3'b101 && esc == 4'b0010, "R7 phase1", st, 5);
    step(2); chk(st == 3'b110, "R7 phase2", st, 6);
    step(1); chk(st == 3'b111 && esc == 4'b1000, "R7 zero length phase2", st, 7);
    step(4); chk(st == 3'b011, "R7 terminal", st, 3);
    cur_req = "R12";
    step(5);
    chk(st == 3'b011 && esc == 0 && cnt == 0, "R12 terminal hold", st, 3);
    cur_req = "R8";
    irq = 0; pulse_clr();
    chk(st == 3'b000, "R8 clear from terminal", st, 0);

    cur_req = "R11";
    smap = 8'b10_10_00_10; sen = 4'b1011;
    set_phases(4, 6, 5, 3);
    step(1); pulse_acc();
    chk(st == 3'b100 && esc == 4'b0010, "R6 trigger from idle", esc, 2);
    step(4);
    chk(st == 3'b101 && esc == 4'b0000, "R11 unmapped phase quiet", esc, 0);
    step(6);
    chk(st == 3'b110 && esc == 4'b1001, "R11 shared phase", esc, 9);
    cur_req = "R8";
    step(2); pulse_clr();
    chk(st == 3'b000, "R8 clear from phase", st, 0);

    cur_req = "R6";
    smap = 8'b11_10_01_00; sen = 4'b1111;
    tmo = 20; irq = 1; step(4);
    chk(st == 3'b001, "R6 in timeout", st, 1);
    pulse_acc();
    chk(st == 3'b100, "R6 trigger from timeout", st, 4);
    irq = 0; pulse_clr(); step(1);

    cur_req = "R10";
    lock = 1; pulse_acc();
    chk(ce == 0, "R10 lock drops flag", ce, 0);
    cur_req = "R8";
    clr = 1; step(1); clr = 0;
    chk(st != 3'b000, "R8 locked clear ignored", st, 4);
    step(25);
    chk(st == 3'b011, "R8 locked reaches terminal", st, 3);
    pulse_clr();
    chk(st == 3'b011, "R8 locked terminal ignores clear", st, 3);

    cur_req = "R9";
    lock = 0; rst_n = 0; step(2); rst_n = 1; step(1);
    chk(ce == 1, "R9 flag reset", ce, 1);
    wipe = 1; step(1); wipe = 0;
    chk(ce == 0, "R9 wipe", ce, 0);
    pulse_acc(); step(1); pulse_clr();
    chk(st != 3'b000, "R9 clear refused after wipe", st, 4);
    step(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule